// File: doc/BRIEF.md
# Adaptive Stochastic Density Estimator

This block keeps a running estimate of how often a serial bit stream carries a 1. Every time a strobe marks a new stream bit, the present estimate is compared against a random number of the same width. The estimate then takes one step toward the stream bit, or holds. Over many strobes the estimate settles near the fraction of ones times full scale.

Any quantity can be measured this way if it is first spread over a group of stream bits. For example, a value of 3 on a 0 to 4 scale becomes three ones in every four bits. The block then reports 75 %, about 192 out of 256. The block only estimates a probability, so one instance serves quantities of any range unchanged. Stream bits may arrive on any cycle, with no framing. The random numbers and the stream are produced outside the block.

Top module: `prob_estimator`

## Requirements
- R1: After reset the estimate equals midscale, 2^(W-1) (128 for W = 8).
- R2: A cycle with `clear` high sets the estimate to midscale on the next edge, whatever `bit_valid` is doing.
- R3: On a cycle with neither `clear` nor `bit_valid`, the estimate does not change.
- R4: On a strobe with `bit_in` = 1 and estimate not greater than `rnd`, the estimate rises by one, unless it is already at full scale (2^W - 1).
- R5: On a strobe with `bit_in` = 0 and estimate greater than `rnd`, the estimate falls by one.
- R6: On a strobe with `bit_in` = 1 and estimate greater than `rnd`, or `bit_in` = 0 and estimate not greater than `rnd`, the estimate holds.
- R7: The estimate saturates at 0 and at 2^W - 1 and never wraps around.
- R8: A single strobe moves the estimate by at most one step.
- R9: With uniformly random `rnd` and a stream whose density of ones is 3/4, the estimate settles around 192 (for W = 8). Its average over a long run stays within 16 of that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous return of the estimate to midscale |
| bit_valid | input | 1 | Strobe: `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| rnd | input | W | Random number for the comparison |
| estimate | output | W | Registered probability estimate, full scale = 2^W |

## Verification
The bench builds the block with its default width of 8. At this width the full-scale saturation is only 127 steps from midscale and the zero floor is 128 steps away, so directed runs can pin the estimate at both ends. At this width the estimate also settles at a 3/4 density within a few thousand strobes. The random phase mixes idle cycles, occasional clears and random comparison values. A cycle model in the bench follows every step.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/pe_compare.sv
module pe_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0] level,
  input  logic [W-1:0] rnd,
  output logic         above
);
  // Estimate strictly exceeds the random sample.
  always_comb above = (level > rnd);
endmodule

// File: rtl/pe_step_decide.sv
module pe_step_decide
  import pe_pkg::*;
(
  input  logic  strobe,
  input  logic  bit_in,
  input  logic  above,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (strobe) begin
      if (bit_in && !above)      step = STEP_UP;
      else if (!bit_in && above) step = STEP_DOWN;
    end
  end
endmodule

// File: rtl/pe_sat_counter.sv
module pe_sat_counter
  import pe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  step_e        step,
  output logic [W-1:0] level
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      level_q <= MID;
    end else begin
      unique case (step)
        STEP_UP:   if (level_q != TOP) level_q <= level_q + W'(1);
        STEP_DOWN: if (level_q != '0)  level_q <= level_q - W'(1);
        default:   level_q <= level_q;
      endcase
    end
  end

  assign level = level_q;
endmodule

// File: rtl/prob_estimator.sv
module prob_estimator
  import pe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic [W-1:0] rnd,
  output logic [W-1:0] estimate
);
  logic         above;
  step_e        step;
  logic [W-1:0] level;

  pe_compare #(.W(W)) u_cmp (
    .level (level),
    .rnd   (rnd),
    .above (above)
  );

  pe_step_decide u_dec (
    .strobe (bit_valid),
    .bit_in (bit_in),
    .above  (above),
    .step   (step)
  );

  pe_sat_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .step  (step),
    .level (level)
  );

  assign estimate = level;
endmodule

// File: rtl/prob_estimator_chk.sv
module prob_estimator_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clear,
  input logic         bit_valid,
  input logic         bit_in,
  input logic [W-1:0] rnd,
  input logic [W-1:0] estimate
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assert_clear_mid_R2: assert property (@(posedge clk) disable iff (rst)
    clear |=> estimate == MID);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!clear && !bit_valid) |=> $stable(estimate));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear && bit_valid && bit_in && estimate <= rnd && estimate != TOP)
    |=> estimate == $past(estimate) + W'(1));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (!clear && bit_valid && !bit_in && estimate > rnd)
    |=> estimate == $past(estimate) - W'(1));

  assert_agree_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!clear && bit_valid && (bit_in == (estimate > rnd))) |=> $stable(estimate));

  assert_no_wrap_top_R7: assert property (@(posedge clk) disable iff (rst)
    (!clear && estimate == TOP) |=> estimate >= TOP - W'(1));

  assert_no_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!clear && estimate == '0) |=> estimate <= W'(1));

  assert_one_step_R8: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (estimate == $past(estimate)) ||
               (estimate == $past(estimate) + W'(1)) ||
               (estimate == $past(estimate) - W'(1)));
endmodule

bind prob_estimator prob_estimator_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .rnd       (rnd),
  .estimate  (estimate)
);

// File: tb/prob_estimator_test.sv
module prob_estimator_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MID = 1 << (W - 1);
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clear = 1'b0;
  logic         bit_valid = 1'b0;
  logic         bit_in = 1'b0;
  logic [W-1:0] rnd = '0;
  logic [W-1:0] estimate;

  int checks = 0;
  int errors = 0;
  int model  = MID;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prob_estimator #(.W(W)) uut (
    .clk(clk), .rst(rst), .clear(clear), .bit_valid(bit_valid),
    .bit_in(bit_in), .rnd(rnd), .estimate(estimate)
  );

  function automatic int next_est(int cur, bit clr, bit v, bit b, int r);
    if (clr) return MID;
    if (!v) return cur;
    if (b && !(cur > r)) return (cur == TOP) ? cur : cur + 1;
    if (!b && (cur > r)) return (cur == 0) ? cur : cur - 1;
    return cur;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one clock and checks result.
  task automatic cycle(bit clr, bit v, bit b, int r, string req);
    clear = clr; bit_valid = v; bit_in = b; rnd = r[W-1:0];
    model = next_est(model, clr, v, b, r);
    @(posedge clk);
    @(negedge clk);
    check(req, int'(estimate), model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset midscale", int'(estimate), MID);

    cycle(0, 0, 1, 0, "R3 idle hold");
    cycle(0, 1, 1, 200, "R4 step up");
    cycle(0, 1, 0, 10, "R5 step down");
    cycle(0, 1, 1, 10, "R6 agree hold one");
    cycle(0, 1, 0, 250, "R6 agree hold zero");
    cycle(0, 1, 1, MID, "R4 equal counts as not above");

    // Climb to full scale and stay there.
    for (int i = 0; i < 140; i++) cycle(0, 1, 1, TOP, "R4 R8 climb");
    check("R7 top saturation", int'(estimate), TOP);
    cycle(0, 1, 1, TOP, "R7 top hold");
    cycle(1, 1, 1, TOP, "R2 clear overrides strobe");

    // Fall to zero and stay there.
    for (int i = 0; i < 140; i++) cycle(0, 1, 0, 0, "R5 R8 fall");
    check("R7 zero saturation", int'(estimate), 0);
    cycle(0, 1, 0, TOP, "R7 zero hold");
    cycle(1, 0, 0, 0, "R2 clear");

    // Random mix of idle, strobes and rare clears.
    for (int i = 0; i < 3000; i++) begin
      int roll = int'($urandom_range(0, 99));
      cycle(roll < 2, roll < 70, $urandom_range(0, 1) == 1,
            int'($urandom_range(0, TOP)), "R4 R5 R6 random");
    end

    // Convergence at density 3/4.
    cycle(1, 0, 0, 0, "R2 clear before convergence");
    begin
      longint sum = 0;
      int avg;
      for (int i = 0; i < 8000; i++) begin
        cycle(0, 1, $urandom_range(0, 3) != 0,
              int'($urandom_range(0, TOP)), "R9 model track");
        if (i >= 4000) sum += longint'(estimate);
      end
      avg = int'(sum / 4000);
      checks++;
      if (avg < 176 || avg > 208) begin
        errors++;
        $display("FAIL R9 convergence actual=%0d expected=192+-16", avg);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule